// File: doc/BRIEF.md
# Host Bridge Address Window Decoder

This block is the CPU-side register file of a host bridge. It decides where two windows sit in the CPU address map. The first is an I/O window. The second is a fixed 4 KB window that exposes the bridge's own register space. Software sets each window with decode registers counted in 2 MB units. The block turns those values into a base and a length and registers the result. It then compares a CPU address against both windows with no clock delay and raises one hit flag per window.

Before a mapping is taken into use, its start and end are trimmed around two fixed reserved holes in the address map, so a window never claims those ranges. An I/O mapping whose low field is larger than its high field is rejected, and the previous mapping stays in force.

A configuration bit selects the byte order of all register traffic. When that bit is clear, write data and read data both pass through a byte reversal.

Top module: `hbw_top`

## Requirements
- R1: After reset, a read returns the following values. Register index 0 (configuration) reads 0x00001000. Index 1 (multi-bridge status) reads 0x3. Index 2 (I/O low decode) reads 0x080. Index 3 (I/O high decode) reads 0x00F. Index 4 (register-space decode) reads 0x0A0. Index 5 (I/O remap) reads 0x080. The I/O window is base 0x10000000 with length 0x02000000. The register window is base 0x14000000 with length 0x1000.
- R2: Each register keeps only part of a write. A write to index 2 keeps bits 14:0 and also loads index 5 with bits 10:0. Index 3 keeps bits 6:0. Index 4 keeps bits 14:0. Index 5 keeps bits 10:0. Index 1 ignores writes. Indices 6 and 7 read as 0.
- R3: A write to index 2 or 3 recomputes the I/O window when (low & 0x7F) <= high. The raw base is low<<21, truncated to 32 bits. The raw length is ((high+1) - (low & 0x7F))<<21. When (low & 0x7F) > high, the previous window is kept.
- R4: Every write to index 4 maps the register window at raw base value<<21 (truncated to 32 bits) with raw length 0x1000.
- R5: Each raw window [begin, end = begin+length) is trimmed in this order, using hole A = [0x1E000000, 0x1F100000) and hole B = [0x1FC00000, 0x1FD00000):
  - an end inside hole A becomes 0x1E000000;
  - a begin inside hole A becomes 0x1F100000;
  - the same two steps are then applied for hole B;
  - an end >= 0x1F100000 with begin < 0x1E000000 becomes 0x1E000000;
  - an end >= 0x1FD00000 with begin < 0x1FC00000 becomes 0x1FC00000.
  The output base is the trimmed begin.
- R6: When the trimmed end is not above the trimmed begin, the window length is 0.
- R7: A hit flag is high exactly when base <= cpu_addr < base+length, evaluated combinationally. A window with length 0 never hits.
- R8: When configuration bit 12 is clear, write data is byte-reversed before it is stored and read data is byte-reversed before it is returned. This includes writes to index 0 itself. When bit 12 is set, no reversal is applied.
- R9: A read request gives rsp_valid with the data one clock later. A write request gives no response.
- R10: Register values and window outputs change on the clock edge that accepts a write, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | register word index |
| req_wdata | input | 32 | write data (bus byte order) |
| rsp_valid | output | 1 | read data valid |
| rsp_rdata | output | 32 | read data (bus byte order) |
| cpu_addr | input | 32 | CPU address to decode |
| io_hit | output | 1 | cpu_addr lies in the I/O window |
| reg_hit | output | 1 | cpu_addr lies in the register window |
| io_base | output | 32 | current I/O window base |
| io_len | output | 32 | current I/O window length |
| reg_base | output | 32 | current register window base |
| reg_len | output | 32 | current register window length |

## Verification
The hardest conditions to reach are the trimming steps around the reserved holes. The low field's bit 7 sets the base but not the length, and the 7-bit length arithmetic rarely places a window across 0x1E000000 or 0x1FC00000. The stimulus sets upper low-field bits to move the base near the holes, then sweeps the high field so the end lands on both sides of each hole. It also moves the register window into hole A, which forces the empty-window case. A near-exhaustive sweep of low and high pairs covers the rejected-update path, where (low & 0x7F) > high must leave the previous I/O mapping in place.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    localparam int DW       = 32;
    localparam int AW       = 32;
    localparam int IDX_W    = 3;
    localparam int GRAN_SH  = 21;
    localparam int WIN_N    = 2;
    localparam int WIN_IO   = 0;
    localparam int WIN_REG  = 1;
    localparam int LO_W     = 15;
    localparam int HI_W     = 7;
    localparam int REMAP_W  = 11;
    localparam int LE_BIT   = 12;

    localparam logic [AW:0] REG_WIN_LEN = 33'h0_0000_1000;

    localparam logic [AW-1:0] HOLE_A_LO = 32'h1E00_0000;
    localparam logic [AW-1:0] HOLE_A_HI = 32'h1F10_0000;
    localparam logic [AW-1:0] HOLE_B_LO = 32'h1FC0_0000;
    localparam logic [AW-1:0] HOLE_B_HI = 32'h1FD0_0000;

    localparam logic [DW-1:0]      CFG_RST   = 32'h0000_1000;
    localparam logic [DW-1:0]      MULTI_VAL = 32'h0000_0003;
    localparam logic [LO_W-1:0]    IOLO_RST  = 15'h080;
    localparam logic [HI_W-1:0]    IOHI_RST  = 7'h0F;
    localparam logic [LO_W-1:0]    RDEC_RST  = 15'h0A0;
    localparam logic [REMAP_W-1:0] REMAP_RST = 11'h080;

    typedef enum logic [IDX_W-1:0] {
        RI_CFG   = 3'd0,
        RI_MULTI = 3'd1,
        RI_IOLO  = 3'd2,
        RI_IOHI  = 3'd3,
        RI_RDEC  = 3'd4,
        RI_REMAP = 3'd5
    } ridx_e;

    typedef struct packed {
        logic [DW-1:0]      cfg;
        logic [LO_W-1:0]    io_lo;
        logic [HI_W-1:0]    io_hi;
        logic [LO_W-1:0]    rdec;
        logic [REMAP_W-1:0] remap;
    } regs_t;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] len;
    } win_t;

    function automatic logic [DW-1:0] swap32(input logic [DW-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [AW-1:0] unit_base(input logic [LO_W-1:0] v);
        logic [AW-1:0] w;
        w = AW'(v);
        return w << GRAN_SH;
    endfunction

    function automatic logic [AW:0] io_raw_len(input logic [LO_W-1:0] lo,
                                               input logic [HI_W-1:0] hi);
        logic [AW:0] n;
        n = (AW+1)'(hi) + 33'd1 - (AW+1)'(lo[HI_W-1:0]);
        return n << GRAN_SH;
    endfunction

    function automatic win_t clip_win(input logic [AW-1:0] start,
                                      input logic [AW:0]   len);
        logic [AW:0] b, e;
        win_t w;
        b = {1'b0, start};
        e = b + len;
        if (e >= {1'b0, HOLE_A_LO} && e < {1'b0, HOLE_A_HI}) e = {1'b0, HOLE_A_LO};
        if (b >= {1'b0, HOLE_A_LO} && b < {1'b0, HOLE_A_HI}) b = {1'b0, HOLE_A_HI};
        if (e >= {1'b0, HOLE_B_LO} && e < {1'b0, HOLE_B_HI}) e = {1'b0, HOLE_B_LO};
        if (b >= {1'b0, HOLE_B_LO} && b < {1'b0, HOLE_B_HI}) b = {1'b0, HOLE_B_HI};
        if (e >= {1'b0, HOLE_A_HI} && b < {1'b0, HOLE_A_LO}) e = {1'b0, HOLE_A_LO};
        if (e >= {1'b0, HOLE_B_HI} && b < {1'b0, HOLE_B_LO}) e = {1'b0, HOLE_B_LO};
        w.base = b[AW-1:0];
        w.len  = (e > b) ? AW'(e - b) : '0;
        return w;
    endfunction

endpackage

// File: rtl/hbw_regs.sv
module hbw_regs
    import hbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [DW-1:0]    req_wdata,
    output regs_t            cur,
    output regs_t            nxt,
    output logic             io_upd,
    output logic             rdec_upd,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata
);

    logic          little;
    logic [DW-1:0] wd;
    logic [DW-1:0] rd_val;
    logic          wr_go;
    ridx_e         idx;

    assign little = cur.cfg[LE_BIT];
    assign wd     = little ? req_wdata : swap32(req_wdata);
    assign wr_go  = req_valid && req_write;
    assign idx    = ridx_e'(req_idx);

    always_comb begin
        nxt      = cur;
        io_upd   = 1'b0;
        rdec_upd = 1'b0;
        if (wr_go) begin
            case (idx)
                RI_CFG:   nxt.cfg = wd;
                RI_IOLO: begin
                    nxt.io_lo = wd[LO_W-1:0];
                    nxt.remap = wd[REMAP_W-1:0];
                    io_upd    = 1'b1;
                end
                RI_IOHI: begin
                    nxt.io_hi = wd[HI_W-1:0];
                    io_upd    = 1'b1;
                end
                RI_RDEC: begin
                    nxt.rdec = wd[LO_W-1:0];
                    rdec_upd = 1'b1;
                end
                RI_REMAP: nxt.remap = wd[REMAP_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            RI_CFG:   rd_val = cur.cfg;
            RI_MULTI: rd_val = MULTI_VAL;
            RI_IOLO:  rd_val = DW'(cur.io_lo);
            RI_IOHI:  rd_val = DW'(cur.io_hi);
            RI_RDEC:  rd_val = DW'(cur.rdec);
            RI_REMAP: rd_val = DW'(cur.remap);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.cfg   <= CFG_RST;
            cur.io_lo <= IOLO_RST;
            cur.io_hi <= IOHI_RST;
            cur.rdec  <= RDEC_RST;
            cur.remap <= REMAP_RST;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            cur       <= nxt;
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= little ? rd_val : swap32(rd_val);
        end
    end

endmodule

// File: rtl/hbw_clip.sv
module hbw_clip
    import hbw_pkg::*;
(
    input  logic [AW-1:0] raw_start,
    input  logic [AW:0]   raw_len,
    output win_t          win
);
    assign win = clip_win(raw_start, raw_len);
endmodule

// File: rtl/hbw_hit.sv
module hbw_hit
    import hbw_pkg::*;
#(
    parameter int N = WIN_N
) (
    input  logic [AW-1:0]    addr,
    input  win_t [N-1:0]     wins,
    output logic [N-1:0]     hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [AW:0] lim;
        assign lim    = {1'b0, wins[i].base} + {1'b0, wins[i].len};
        assign hit[i] = (wins[i].len != '0) && (addr >= wins[i].base)
                        && ({1'b0, addr} < lim);
    end
endmodule

// File: rtl/hbw_top.sv
module hbw_top
    import hbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    input  logic [AW-1:0]    cpu_addr,
    output logic             io_hit,
    output logic             reg_hit,
    output logic [AW-1:0]    io_base,
    output logic [AW-1:0]    io_len,
    output logic [AW-1:0]    reg_base,
    output logic [AW-1:0]    reg_len
);

    regs_t cur, nxt;
    logic  io_upd, rdec_upd;
    logic  io_ok;

    logic [AW-1:0]    raw_start [WIN_N];
    logic [AW:0]      raw_len   [WIN_N];
    win_t             clipped   [WIN_N];
    win_t             rst_win   [WIN_N];
    logic [WIN_N-1:0] take;
    win_t [WIN_N-1:0] win_q;
    logic [WIN_N-1:0] hits;

    hbw_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .cur       (cur),
        .nxt       (nxt),
        .io_upd    (io_upd),
        .rdec_upd  (rdec_upd),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign io_ok = nxt.io_lo[HI_W-1:0] <= nxt.io_hi;

    assign raw_start[WIN_IO]  = unit_base(nxt.io_lo);
    assign raw_len[WIN_IO]    = io_raw_len(nxt.io_lo, nxt.io_hi);
    assign take[WIN_IO]       = io_upd && io_ok;
    assign rst_win[WIN_IO]    = clip_win(unit_base(IOLO_RST), io_raw_len(IOLO_RST, IOHI_RST));

    assign raw_start[WIN_REG] = unit_base(nxt.rdec);
    assign raw_len[WIN_REG]   = REG_WIN_LEN;
    assign take[WIN_REG]      = rdec_upd;
    assign rst_win[WIN_REG]   = clip_win(unit_base(RDEC_RST), REG_WIN_LEN);

    for (genvar i = 0; i < WIN_N; i++) begin : g_win
        hbw_clip u_clip (
            .raw_start (raw_start[i]),
            .raw_len   (raw_len[i]),
            .win       (clipped[i])
        );
        always_ff @(posedge clk) begin
            if (rst)          win_q[i] <= rst_win[i];
            else if (take[i]) win_q[i] <= clipped[i];
        end
    end

    hbw_hit #(.N(WIN_N)) u_hit (
        .addr (cpu_addr),
        .wins (win_q),
        .hit  (hits)
    );

    assign io_hit   = hits[WIN_IO];
    assign reg_hit  = hits[WIN_REG];
    assign io_base  = win_q[WIN_IO].base;
    assign io_len   = win_q[WIN_IO].len;
    assign reg_base = win_q[WIN_REG].base;
    assign reg_len  = win_q[WIN_REG].len;

endmodule

// File: rtl/hbw_chk.sv
module hbw_chk
    import hbw_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic          rsp_valid,
    input logic [AW-1:0] cpu_addr,
    input logic          io_hit,
    input logic          reg_hit,
    input logic [AW-1:0] io_base,
    input logic [AW-1:0] io_len,
    input logic [AW-1:0] reg_base,
    input logic [AW-1:0] reg_len
);
    logic in_hole;
    assign in_hole = (cpu_addr >= HOLE_A_LO && cpu_addr < HOLE_A_HI) ||
                     (cpu_addr >= HOLE_B_LO && cpu_addr < HOLE_B_HI);

    // R7
    empty_io_chk: assert property (@(posedge clk) disable iff (rst)
        (io_len == '0) |-> !io_hit);

    // R7
    empty_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_len == '0) |-> !reg_hit);

    // R5
    hole_clear_chk: assert property (@(posedge clk) disable iff (rst)
        in_hole |-> !(io_hit || reg_hit));

    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R9
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);

    // R10
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(io_base) && $stable(io_len) &&
                        $stable(reg_base) && $stable(reg_len)));

    // R4
    reg_size_chk: assert property (@(posedge clk) disable iff (rst)
        reg_len <= 32'h1000);
endmodule

bind hbw_top hbw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .cpu_addr  (cpu_addr),
    .io_hit    (io_hit),
    .reg_hit   (reg_hit),
    .io_base   (io_base),
    .io_len    (io_len),
    .reg_base  (reg_base),
    .reg_len   (reg_len)
);

// File: tb/tb_hbw_top.sv
module tb_hbw_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] cpu_addr = '0;
    logic        io_hit, reg_hit;
    logic [31:0] io_base, io_len, reg_base, reg_len;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    hbw_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .cpu_addr(cpu_addr), .io_hit(io_hit),
        .reg_hit(reg_hit), .io_base(io_base), .io_len(io_len),
        .reg_base(reg_base), .reg_len(reg_len)
    );

    // bench-side model state
    longint m_io_b, m_io_l, m_rg_b, m_rg_l;
    int     m_lo, m_hi;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic void trim(input longint s, input longint l,
                                 output longint b, output longint ln);
        longint e;
        e = s + l;
        b = s;
        if (e >= 64'h1E000000 && e < 64'h1F100000) e = 64'h1E000000;
        if (b >= 64'h1E000000 && b < 64'h1F100000) b = 64'h1F100000;
        if (e >= 64'h1FC00000 && e < 64'h1FD00000) e = 64'h1FC00000;
        if (b >= 64'h1FC00000 && b < 64'h1FD00000) b = 64'h1FD00000;
        if (e >= 64'h1F100000 && b < 64'h1E000000) e = 64'h1E000000;
        if (e >= 64'h1FD00000 && b < 64'h1FC00000) e = 64'h1FC00000;
        ln = (e > b) ? e - b : 0;
    endfunction

    function automatic longint base_of(input int v);
        return (longint'(v) << 21) & 64'hFFFF_FFFF;
    endfunction

    task automatic model_io();
        if ((m_lo & 'h7F) <= m_hi)
            trim(base_of(m_lo), longint'((m_hi + 1) - (m_lo & 'h7F)) << 21, m_io_b, m_io_l);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_idx = idx; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_idx = idx;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; v = rsp_valid;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] idx, input logic [31:0] exp);
        logic [31:0] d; logic v;
        rd(idx, d, v);
        chk({tag, " rsp_valid"}, longint'(v), 1);
        chk(tag, longint'(d), longint'(exp));
    endtask

    task automatic hitchk(input string tag, input logic [31:0] a);
        longint ea;
        ea = longint'(a);
        cpu_addr = a;
        #1;
        chk({tag, " io_hit"}, longint'(io_hit),
            longint'(m_io_l != 0 && ea >= m_io_b && ea < m_io_b + m_io_l));
        chk({tag, " reg_hit"}, longint'(reg_hit),
            longint'(m_rg_l != 0 && ea >= m_rg_b && ea < m_rg_b + m_rg_l));
    endtask

    task automatic mapchk(input string tag);
        chk({tag, " io_base"}, longint'(io_base), m_io_b);
        chk({tag, " io_len"},  longint'(io_len),  m_io_l);
        chk({tag, " reg_base"}, longint'(reg_base), m_rg_b);
        chk({tag, " reg_len"},  longint'(reg_len),  m_rg_l);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d; logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rsp_valid idle", longint'(rsp_valid), 0);
        rdchk("R1 cfg",   3'd0, 32'h1000);
        rdchk("R1 multi", 3'd1, 32'h3);
        rdchk("R1 io_lo", 3'd2, 32'h080);
        rdchk("R1 io_hi", 3'd3, 32'h00F);
        rdchk("R1 rdec",  3'd4, 32'h0A0);
        rdchk("R1 remap", 3'd5, 32'h080);
        m_io_b = 64'h1000_0000; m_io_l = 64'h0200_0000;
        m_rg_b = 64'h1400_0000; m_rg_l = 64'h1000;
        m_lo = 'h80; m_hi = 'h0F;
        mapchk("R1 map");

        // R7 hit edges around reset windows
        hitchk("R7 io below", 32'h0FFF_FFFF);
        hitchk("R7 io first", 32'h1000_0000);
        hitchk("R7 io last",  32'h11FF_FFFF);
        hitchk("R7 io past",  32'h1200_0000);
        hitchk("R7 rg first", 32'h1400_0000);
        hitchk("R7 rg last",  32'h1400_0FFF);
        hitchk("R7 rg past",  32'h1400_1000);

        // R2 masking, remap side load, read-only and empty slots
        wr(3'd2, 32'hFFFF_A885);
        m_lo = 'h2885; model_io();
        rdchk("R2 io_lo mask", 3'd2, 32'h2885);
        rdchk("R2 remap load", 3'd5, 32'h085);
        wr(3'd5, 32'hFFFF_F123);
        rdchk("R2 remap mask", 3'd5, 32'h123);
        wr(3'd1, 32'h1234_5678);
        rdchk("R2 multi ro", 3'd1, 32'h3);
        wr(3'd6, 32'hFFFF_FFFF);
        rdchk("R2 idx6 zero", 3'd6, 32'h0);
        rdchk("R2 idx7 zero", 3'd7, 32'h0);
        wr(3'd3, 32'hFFFF_FF85);
        m_hi = 'h05; model_io();
        rdchk("R2 io_hi mask", 3'd3, 32'h05);
        mapchk("R3 after mask writes");

        // R3 near-exhaustive sweep of low/high fields (rejects included)
        for (int lo7 = 0; lo7 < 128; lo7 += 9) begin
            m_lo = lo7 | ((lo7 & 1) ? 'h80 : 'h0);
            wr(3'd2, m_lo); model_io();
            mapchk("R3 lo write");
            for (int hi = 0; hi < 128; hi++) begin
                m_hi = hi;
                wr(3'd3, hi); model_io();
                chk("R3 io_base", longint'(io_base), m_io_b);
                chk("R3 io_len",  longint'(io_len),  m_io_l);
                if ((hi % 16) == 5) begin
                    hitchk("R7 sweep base", io_base);
                    hitchk("R7 sweep end",  io_base + io_len);
                    hitchk("R7 sweep last", io_base + io_len - 32'd1);
                end
            end
        end

        // R5 window crossing hole A: base 0x1C000000, raw end 0x20000000
        wr(3'd3, 32'h7F); m_hi = 'h7F;
        wr(3'd2, 32'hE0); m_lo = 'hE0; model_io();
        chk("R5 split A base", longint'(io_base), 64'h1C00_0000);
        chk("R5 split A len",  longint'(io_len),  64'h0200_0000);
        hitchk("R5 hole A edge", 32'h1E00_0000);
        hitchk("R5 below hole A", 32'h1DFF_FFFF);

        // R5 begin in hole A, end past hole B
        wr(3'd2, 32'hF8); m_lo = 'hF8; model_io();
        chk("R5 begin A base", longint'(io_base), 64'h1F10_0000);
        chk("R5 begin A len",  longint'(io_len),  64'h00B0_0000);
        hitchk("R5 hole B", 32'h1FC0_0000);
        hitchk("R5 pre hole B", 32'h1FBF_FFFF);
        hitchk("R5 first after A", 32'h1F10_0000);

        // R4 R6 register window moved into hole A -> empty
        wr(3'd4, 32'hF0);
        m_rg_b = 64'h1F10_0000; m_rg_l = 0;
        chk("R6 rdec empty base", longint'(reg_base), m_rg_b);
        chk("R6 rdec empty len",  longint'(reg_len),  0);
        hitchk("R6 empty nohit", 32'h1E00_0000);
        hitchk("R6 empty nohit2", 32'h1F10_0000);
        // R4 upper decode bits drop out of the 32-bit base
        wr(3'd4, 32'h0000_7FA1);
        trim(base_of('h7FA1), 64'h1000, m_rg_b, m_rg_l);
        chk("R4 rdec base", longint'(reg_base), m_rg_b);
        chk("R4 rdec len",  longint'(reg_len),  m_rg_l);
        hitchk("R4 rdec hit", reg_base + 32'hFFF);

        // R10 read does not move mapping; read-data timing R9
        rd(3'd4, d, v);
        chk("R9 rd valid", longint'(v), 1);
        chk("R9 rd data",  longint'(d), 64'h7FA1);
        @(negedge clk);
        chk("R9 valid drops", longint'(rsp_valid), 0);
        mapchk("R10 stable");

        // R8 switch to reversed byte order
        wr(3'd0, 32'h0000_0000);
        rdchk("R8 cfg swapped read", 3'd0, 32'h0);
        rdchk("R8 multi swapped", 3'd1, 32'h0300_0000);
        wr(3'd3, 32'h1F00_0000); m_hi = 'h1F;
        m_lo = 'hF8; model_io();
        rdchk("R8 io_hi stored", 3'd3, 32'h1F00_0000);
        wr(3'd2, 32'h0A00_0000); m_lo = 'h0A; model_io();
        mapchk("R8 map via swapped write");
        wr(3'd0, 32'h0010_0000);
        rdchk("R8 cfg restore", 3'd0, 32'h1000);
        rdchk("R8 io_lo plain", 3'd2, 32'h0A);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule